// File: doc/BRIEF.md
# FIFO Read-Side Retransmit Controller

This block sits on the read side of a dual-clock FIFO and owns the read pointer. In normal operation it advances the pointer on every accepted read and keeps the active-low empty flag up to date against a write pointer that has already been brought into the read clock domain. When the retransmit input is found low on a read-clock edge, the controller enters a short setup phase: it rewinds the read pointer to memory location zero, ignores reads for a fixed number of cycles, and then recomputes the empty flag. The data already read can then be fetched again from the start of memory.

Retransmit is only meaningful when the FIFO has moved a limited amount of data since the last reset. The controller counts words written (from the advance of the write pointer) and words read since the last master or partial reset. It raises a sticky error when a retransmit arrives outside the legal window or while a read or write strobe is still active. In first-word-fall-through mode the window uses a depth one word larger than the memory.

Top module: `rtx_ctrl`

## Requirements
- R1: After master reset (`rst_n` low) `rd_addr` is 0, `ef_n` is low, `rt_busy` is low and `rt_err` is low.
- R2: A read is accepted (`rd_en_mem` high) only when `ren_n` is low, `rt_n` is high, `ef_n` is high, `prst_n` is high and no setup is running; each accepted read advances `rd_addr` by one (modulo DEPTH) at the clock edge, and `ef_n` is then registered high exactly when the read pointer (DEPTH*2 modulo) differs from `wr_ptr`.
- R3: `rt_n` low on a rising edge while no setup is running starts setup; `rd_addr` is 0 after that edge and later reads start from address 0.
- R4: With `fwft_mode` low, `ef_n` is driven low on the edge that starts setup; with `fwft_mode` high, `ef_n` keeps its value through setup.
- R5: `rt_busy` is high for exactly SETUP_CYC (default 2) cycles after the starting edge; during setup no read is accepted, `rd_addr` stays 0 and a low `rt_n` starts nothing new.
- R6: On the edge that ends setup, `ef_n` is set high exactly when `wr_ptr` differs from zero (the rewound read pointer).
- R7: A retransmit started while `ren_n` or `wen_n` is low sets `rt_err`; the rewind still takes place.
- R8: A retransmit sets `rt_err` when, counted up to the previous edge, fewer than 2 words were written or read, or more than EFF-2 were, with EFF = DEPTH when `fwft_mode` is low and DEPTH+1 when it is high.
- R9: `rt_err` stays high until the next master reset; partial reset does not clear it.
- R10: `prst_n` low on an edge clears both word counts, sets the read address to 0, ends any setup and drives `ef_n` low.
- R11: The written-word count is the sum of the advances of `wr_ptr` between edges, taken modulo 2*DEPTH so that pointer wrap is counted correctly, saturating at DEPTH+1; a partial reset restarts counting from the current `wr_ptr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Master reset, asynchronous assert, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| fwft_mode | input | 1 | 1 selects first-word-fall-through timing |
| rt_n | input | 1 | Retransmit request, active low |
| ren_n | input | 1 | Read enable, active low |
| wen_n | input | 1 | Write enable seen in the read domain, active low |
| wr_ptr | input | $clog2(DEPTH)+1 | Write pointer synchronised to the read clock |
| rd_en_mem | output | 1 | Read strobe to the memory array |
| rd_addr | output | $clog2(DEPTH) | Read address to the memory array |
| ef_n | output | 1 | Empty flag, active low |
| rt_busy | output | 1 | Retransmit setup in progress |
| rt_err | output | 1 | Sticky illegal-retransmit indication |

## Verification
The in-line assertions watch, on every cycle, that no read is issued while the FIFO reads empty or while setup runs, that the address holds still through setup and sits at zero when setup begins, that the empty flag falls at setup in standard mode, and that the error never drops outside a master reset. Whether the error rises for the right reasons (a count one below or one above the window, the extra word of fall-through mode, a wrapped write pointer, counts cleared by partial reset) only shows up in the bench's scenarios, where a behavioural model tracks the word counts and compares every output each clock.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

  typedef enum logic [0:0] {
    RTX_IDLE  = 1'b0,
    RTX_SETUP = 1'b1
  } rtx_state_e;

endpackage

// File: rtl/rtx_wcount.sv
// Counts words written since reset from the advance of the read-domain
// write pointer. Advance is taken modulo the pointer range.
module rtx_wcount #(
  parameter int PTR_W = 5,
  parameter int CNT_W = 6,
  parameter int SAT   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] wr_cnt
);

  logic [PTR_W-1:0] prev_q, prev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] step;
  logic [CNT_W:0]   sum;

  always_comb begin
    step = wr_ptr - prev_q;
    sum  = {1'b0, cnt_q} + {{(CNT_W + 1 - PTR_W){1'b0}}, step};
    if (clr) begin
      prev_d = wr_ptr;
      cnt_d  = '0;
    end else begin
      prev_d = wr_ptr;
      if (sum > (CNT_W + 1)'(SAT)) cnt_d = CNT_W'(SAT);
      else                         cnt_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wr_cnt = cnt_q;

  // R11: count never exceeds the saturation limit
  a_r11_wcnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SAT));

endmodule

// File: rtl/rtx_rptr.sv
// Read pointer and words-read counter.
module rtx_rptr #(
  parameter int PTR_W = 5,
  parameter int CNT_W = 6,
  parameter int SAT   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             rd_en,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] rd_ptr_nxt,
  output logic [CNT_W-1:0] rd_cnt
);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_ce, cnt_ce;

  always_comb begin
    ptr_ce = clr | load | rd_en;
    cnt_ce = clr | (rd_en & (cnt_q < CNT_W'(SAT)));
    if (clr || load) ptr_d = '0;
    else             ptr_d = ptr_q + PTR_W'(1);
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ptr_ce) ptr_q <= ptr_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assign rd_ptr     = ptr_q;
  assign rd_ptr_nxt = ptr_ce ? ptr_d : ptr_q;
  assign rd_cnt     = cnt_q;

  // R2: an accepted read moves the pointer by exactly one
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !clr && !load) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

endmodule

// File: rtl/rtx_window.sv
// Legality test of a retransmit request against the words moved since reset.
module rtx_window #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 6
) (
  input  logic             fwft_mode,
  input  logic             ren_n,
  input  logic             wen_n,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] rd_cnt,
  output logic             legal
);

  localparam int LO = 2;

  logic [CNT_W:0] hi_lim;
  logic           cnt_ok, strobes_ok;

  always_comb begin
    hi_lim     = (CNT_W + 1)'(DEPTH - 2) + {{CNT_W{1'b0}}, fwft_mode};
    cnt_ok     = ({1'b0, wr_cnt} >= (CNT_W + 1)'(LO)) &&
                 ({1'b0, rd_cnt} >= (CNT_W + 1)'(LO)) &&
                 ({1'b0, wr_cnt} <= hi_lim) &&
                 ({1'b0, rd_cnt} <= hi_lim);
    strobes_ok = ren_n & wen_n;
    legal      = cnt_ok & strobes_ok;
  end

endmodule

// File: rtl/rtx_ctrl.sv
// Read-side retransmit controller: read pointer, empty flag, setup sequencing
// and legality checking of retransmit requests.
module rtx_ctrl
  import rtx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int SETUP_CYC = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       prst_n,
  input  logic                       fwft_mode,
  input  logic                       rt_n,
  input  logic                       ren_n,
  input  logic                       wen_n,
  input  logic [$clog2(DEPTH):0]     wr_ptr,
  output logic                       rd_en_mem,
  output logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic                       ef_n,
  output logic                       rt_busy,
  output logic                       rt_err
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int CNT_W  = PTR_W + 1;
  localparam int SAT    = DEPTH + 1;
  localparam int SC_W   = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  rtx_state_e       state_q, state_d;
  logic [SC_W-1:0]  cnt_q, cnt_d;
  logic             ef_q, ef_d;
  logic             err_q, err_d;

  logic             busy, req_acc, rd_go, legal, clr;
  logic [PTR_W-1:0] rd_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0] wr_cnt, rd_cnt;

  assign clr     = ~prst_n;
  assign busy    = (state_q == RTX_SETUP);
  assign req_acc = ~busy & ~rt_n & prst_n;
  assign rd_go   = ~busy & rt_n & ~ren_n & ef_q & prst_n;

  rtx_wcount #(.PTR_W(PTR_W), .CNT_W(CNT_W), .SAT(SAT)) u_wcount (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .wr_ptr (wr_ptr),
    .wr_cnt (wr_cnt)
  );

  rtx_rptr #(.PTR_W(PTR_W), .CNT_W(CNT_W), .SAT(SAT)) u_rptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .load       (req_acc),
    .rd_en      (rd_go),
    .rd_ptr     (rd_ptr),
    .rd_ptr_nxt (rd_ptr_nxt),
    .rd_cnt     (rd_cnt)
  );

  rtx_window #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_window (
    .fwft_mode (fwft_mode),
    .ren_n     (ren_n),
    .wen_n     (wen_n),
    .wr_cnt    (wr_cnt),
    .rd_cnt    (rd_cnt),
    .legal     (legal)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ef_d    = ef_q;
    err_d   = err_q;
    if (clr) begin
      state_d = RTX_IDLE;
      cnt_d   = '0;
      ef_d    = 1'b0;
    end else if (req_acc) begin
      state_d = RTX_SETUP;
      cnt_d   = SC_W'(SETUP_CYC - 1);
      ef_d    = fwft_mode ? ef_q : 1'b0;
      if (!legal) err_d = 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) begin
        state_d = RTX_IDLE;
        ef_d    = (rd_ptr != wr_ptr);
      end else begin
        cnt_d = cnt_q - SC_W'(1);
      end
    end else begin
      ef_d = (rd_ptr_nxt != wr_ptr);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RTX_IDLE;
      cnt_q   <= '0;
      ef_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ef_q    <= ef_d;
      err_q   <= err_d;
    end
  end

  assign rd_en_mem = rd_go;
  assign rd_addr   = rd_ptr[ADDR_W-1:0];
  assign ef_n      = ef_q;
  assign rt_busy   = busy;
  assign rt_err    = err_q;

  // R2: never read from an empty FIFO
  a_r2_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !ef_n |-> !rd_en_mem);

  // R3: setup always begins with the address at location zero
  a_r3_rewind_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rt_busy) |-> (rd_addr == '0));

  // R4: standard mode pulls the empty flag low when setup starts
  a_r4_std_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    (req_acc && !fwft_mode) |=> !ef_n);

  // R5: no memory read while setup runs
  a_r5_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rt_busy |-> !rd_en_mem);

  // R5: address frozen during setup
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_busy && prst_n) |=> $stable(rd_addr));

  // R9: error stays set outside master reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rt_err |=> rt_err);

endmodule

// File: tb/rtx_ctrl_bench.sv
module rtx_ctrl_bench;

  localparam int  DEPTH  = 16;
  localparam int  SETUP  = 2;
  localparam int  PTR_W  = $clog2(DEPTH) + 1;
  localparam int  PRANGE = 2 * DEPTH;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG = 20000;

  logic             clk;
  logic             rst_n, prst_n, fwft_mode, rt_n, ren_n, wen_n;
  logic [PTR_W-1:0] wr_ptr;
  logic             rd_en_mem, ef_n, rt_busy, rt_err;
  logic [PTR_W-2:0] rd_addr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  rtx_ctrl #(.DEPTH(DEPTH), .SETUP_CYC(SETUP)) u_rtx_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .prst_n    (prst_n),
    .fwft_mode (fwft_mode),
    .rt_n      (rt_n),
    .ren_n     (ren_n),
    .wen_n     (wen_n),
    .wr_ptr    (wr_ptr),
    .rd_en_mem (rd_en_mem),
    .rd_addr   (rd_addr),
    .ef_n      (ef_n),
    .rt_busy   (rt_busy),
    .rt_err    (rt_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_rp, m_rc, m_wc, m_prev, m_busy;
  bit m_ef, m_err;

  function automatic bit m_rd();
    return (m_busy == 0) && rt_n && !ren_n && m_ef && prst_n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rp = 0; m_rc = 0; m_wc = 0; m_prev = 0; m_busy = 0;
      m_ef = 0; m_err = 0;
    end else begin
      bit rd;
      int eff;
      int adv;
      rd  = m_rd();
      eff = DEPTH + (fwft_mode ? 1 : 0);
      if (!prst_n) begin
        m_rp = 0; m_rc = 0; m_wc = 0; m_prev = int'(wr_ptr); m_busy = 0;
        m_ef = 0;
      end else begin
        if (m_busy == 0 && !rt_n) begin
          if (!ren_n || !wen_n || m_wc < 2 || m_rc < 2 ||
              m_wc > eff - 2 || m_rc > eff - 2) m_err = 1;
          m_rp = 0;
          m_busy = SETUP;
          if (!fwft_mode) m_ef = 0;
        end else if (m_busy > 0) begin
          m_busy--;
          if (m_busy == 0) m_ef = (m_rp != int'(wr_ptr));
        end else begin
          if (rd) begin
            m_rp = (m_rp + 1) % PRANGE;
            if (m_rc < DEPTH + 1) m_rc++;
          end
          m_ef = (m_rp != int'(wr_ptr));
        end
        adv = (int'(wr_ptr) - m_prev + PRANGE) % PRANGE;
        m_wc = (m_wc + adv > DEPTH + 1) ? DEPTH + 1 : m_wc + adv;
        m_prev = int'(wr_ptr);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 rd_addr vs model", int'(rd_addr), m_rp % DEPTH);
      check("R6 ef_n vs model", int'(ef_n), int'(m_ef));
      check("R5 rt_busy vs model", int'(rt_busy), int'(m_busy > 0));
      check("R8 rt_err vs model", int'(rt_err), int'(m_err));
      check("R2 rd_en_mem vs model", int'(rd_en_mem), int'(m_rd()));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic master_reset(input bit fwft);
    rst_n = 1'b0; prst_n = 1'b1; fwft_mode = fwft;
    rt_n = 1'b1; ren_n = 1'b1; wen_n = 1'b1; wr_ptr = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic read_n(input int n);
    ren_n = 1'b0;
    cyc(n);
    ren_n = 1'b1;
  endtask

  task automatic retransmit(input bit ren_low);
    rt_n = 1'b0;
    if (ren_low) ren_n = 1'b0;
    cyc(1);
    rt_n = 1'b1;
    ren_n = 1'b1;
  endtask

  initial begin
    master_reset(1'b0);
    // R1: reset state
    check("R1 rd_addr", int'(rd_addr), 0);
    check("R1 ef_n", int'(ef_n), 0);
    check("R1 rt_busy", int'(rt_busy), 0);
    check("R1 rt_err", int'(rt_err), 0);

    // Normal reads, then a legal retransmit (standard mode)
    wr_ptr = PTR_W'(5);
    cyc(2);
    check("R2 ef_n high with data", int'(ef_n), 1);
    read_n(3);
    cyc(1);
    check("R2 three reads", int'(rd_addr), 3);
    retransmit(1'b0);
    check("R3 rewound address", int'(rd_addr), 0);
    check("R4 std flag forced low", int'(ef_n), 0);
    check("R5 setup running", int'(rt_busy), 1);
    check("R8 legal request no error", int'(rt_err), 0);
    ren_n = 1'b0;
    #1;
    check("R5 read blocked in setup", int'(rd_en_mem), 0);
    cyc(1);
    check("R5 still in setup", int'(rt_busy), 1);
    check("R5 address held", int'(rd_addr), 0);
    cyc(1);
    check("R5 setup ends after two cycles", int'(rt_busy), 0);
    check("R6 flag recomputed", int'(ef_n), 1);
    cyc(5);
    ren_n = 1'b1;
    check("R3 reread from start", int'(rd_addr), 5);
    check("R2 empty after draining", int'(ef_n), 0);
    cyc(1);

    // Retransmit while read enable is active
    retransmit(1'b1);
    check("R7 error on active strobe", int'(rt_err), 1);
    check("R7 rewind still done", int'(rd_addr), 0);
    cyc(3);
    wen_n = 1'b0;
    prst_n = 1'b0; wr_ptr = '0;
    cyc(1);
    prst_n = 1'b1; wen_n = 1'b1;
    check("R9 partial reset keeps error", int'(rt_err), 1);
    check("R10 partial reset address", int'(rd_addr), 0);
    check("R10 partial reset flag", int'(ef_n), 0);
    cyc(2);

    // Partial reset clears the counters: too few words afterwards
    master_reset(1'b0);
    wr_ptr = PTR_W'(5);
    cyc(2);
    read_n(3);
    cyc(1);
    prst_n = 1'b0; wr_ptr = '0;
    cyc(1);
    prst_n = 1'b1;
    wr_ptr = PTR_W'(1);
    cyc(2);
    read_n(1);
    cyc(1);
    check("R10 counters cleared no error yet", int'(rt_err), 0);
    retransmit(1'b0);
    check("R10 R8 too few words", int'(rt_err), 1);
    cyc(3);

    // First-word-fall-through: EFF-2 = 15 is still legal
    master_reset(1'b1);
    wr_ptr = PTR_W'(15);
    cyc(2);
    read_n(2);
    cyc(1);
    check("R4 fwft flag high before", int'(ef_n), 1);
    retransmit(1'b0);
    check("R8 fwft upper bound legal", int'(rt_err), 0);
    check("R4 fwft flag kept in setup", int'(ef_n), 1);
    cyc(3);

    // Standard mode: 15 words exceeds DEPTH-2
    master_reset(1'b0);
    wr_ptr = PTR_W'(15);
    cyc(2);
    read_n(2);
    cyc(1);
    retransmit(1'b0);
    check("R8 std upper bound exceeded", int'(rt_err), 1);
    cyc(3);

    // Standard mode: exactly 14 words is legal, one more write is not
    master_reset(1'b0);
    wr_ptr = PTR_W'(14);
    cyc(2);
    read_n(2);
    cyc(1);
    retransmit(1'b0);
    check("R8 std limit exact legal", int'(rt_err), 0);
    cyc(3);

    // Write pointer wrap after partial reset: 30 -> 2 counts four words
    master_reset(1'b0);
    wr_ptr = PTR_W'(30);
    cyc(1);
    prst_n = 1'b0;
    cyc(1);
    prst_n = 1'b1;
    cyc(1);
    read_n(2);
    wr_ptr = PTR_W'(2);
    cyc(2);
    retransmit(1'b0);
    check("R11 wrapped advance counted", int'(rt_err), 0);
    cyc(3);
    wr_ptr = PTR_W'(22);
    cyc(2);
    retransmit(1'b0);
    check("R11 large advance saturates out of window", int'(rt_err), 1);
    cyc(3);

    finish_run();
  end

endmodule